// File: doc/BRIEF.md
# Modulo Up-Counter Timer with Register Access

This block is a general-purpose timer that counts upward from a programmable start value to a programmable terminal value. When it reaches the terminal value it reloads the start value and records the event in a sticky flag. The flag can raise a level interrupt. Software drives the timer through a 32-bit register port that is synchronous to the system clock. The port has an address, write data, a write strobe and combinational read data. A 3-bit code sets a power-of-two prescaler that slows the count rate. A two-bit source field starts and stops counting.

The same block serves two purposes. As an event source, software stops the timer, reloads it, programs a terminal value of N-1 and restarts it, and receives one wrap every N prescaled ticks. As a timestamp, software leaves the terminal value at its maximum and reads the count whenever it needs the time. An elaboration parameter selects big-endian byte lanes, which swaps the bytes of every register word in both directions.

Top module: `mtim_top`

## Requirements
- R1: After reset, the control word reads 0x00, the count reads 0, the initial value reads 0, the terminal value reads 0x0000FFFF, and the interrupt is low.
- R2: The control word is at offset 0x00, the count at 0x04, the terminal value at 0x08 and the initial value at 0x4C. The terminal value and initial value store the low 16 bits. In the control word, bits [2:0] hold the prescaler code, bits [4:3] the source select, bit 6 the interrupt enable and bit 7 the wrap flag. All other bits read 0.
- R3: The count advances only while the source select equals 1. Any other source value holds the count.
- R4: With prescaler code p, the count advances once every 2^p clocks. After counting is enabled, the first advance comes a full 2^p clocks later.
- R5: On a tick where the count equals the terminal value, the count takes the initial value and the wrap flag sets on that same clock edge. With an initial value of 0 and a terminal value of N-1, one wrap occurs every N ticks.
- R6: A write of any data to the count offset loads the initial value into the count and restarts the prescaler phase.
- R7: A control write with bit 7 at 0 clears the wrap flag. A control write with bit 7 at 1 never sets the flag.
- R8: If a wrap occurs on the same edge as a control write that clears the flag, the flag stays set.
- R9: The interrupt output is a level equal to the wrap flag ANDed with the interrupt enable.
- R10: With the big-endian parameter set, the bytes of the write data are reversed before use and the bytes of the read data are reversed before output. For example, a control write of 0x08000000 starts counting, and a count of 2 reads back as 0x02000000.
- R11: The sequence of stop, reload, new terminal value and restart produces a full fresh period before the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the counting source |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Level interrupt: wrap flag AND enable |

## Verification
The bench targets the edge where the count equals the terminal value and checks that the reload and the flag land together. A design that is off by one there would give N+1 or N-1 ticks per period. A clear write is placed exactly on a wrap edge, and a design with the wrong priority would lose that event. Reads are made on each side of the first prescaled tick after enable and after a count write, which exposes a divider that is not restarted. A second instance with swapped lanes shows whether the byte reversal covers both write and read.

// File: rtl/mtim_pkg.sv
// Package: shared offsets, control-field layout and byte-lane helper for the timer.
// Assumes: 32-bit register words, byte offsets on the bus.
package mtim_pkg;

    localparam logic [7:0] OFS_CTL  = 8'h00;
    localparam logic [7:0] OFS_CNT  = 8'h04;
    localparam logic [7:0] OFS_MOD  = 8'h08;
    localparam logic [7:0] OFS_INIT = 8'h4C;

    localparam int PS_W       = 3;
    localparam int SRC_LSB    = 3;
    localparam int IE_BIT     = 6;
    localparam int FLAG_BIT   = 7;
    localparam logic [1:0] SRC_RUN = 2'd1;

    // Control word held in the block, packed in register bit order (bit 5 unused).
    typedef struct packed {
        logic            flag;
        logic            ie;
        logic [1:0]      src;
        logic [PS_W-1:0] ps;
    } ctl_t;

    // Reverse byte order of a 32-bit word.
    function automatic logic [31:0] swap_bytes(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

endpackage

// File: rtl/mtim_lanes.sv
// Byte-lane adapter: passes register data straight through or byte-reversed.
// Assumes: the variant is fixed at elaboration by BIG_ENDIAN.
module mtim_lanes #(
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic [31:0] wdata_ext,
    output logic [31:0] wdata_int,
    input  logic [31:0] rdata_int,
    output logic [31:0] rdata_ext
);
    import mtim_pkg::*;

    generate
        if (BIG_ENDIAN) begin : g_swap
            // Reverse bytes in both directions.
            assign wdata_int = swap_bytes(wdata_ext);
            assign rdata_ext = swap_bytes(rdata_int);
        end else begin : g_pass
            // Native order.
            assign wdata_int = wdata_ext;
            assign rdata_ext = rdata_int;
        end
    endgenerate

endmodule

// File: rtl/mtim_prescaler.sv
// Power-of-two prescaler: emits a one-cycle tick every 2^ps_code clocks while run is high.
// Assumes: the divider restarts from zero whenever run is low or clear is pulsed,
// so the first tick after either comes a full period later.
module mtim_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clear,
    input  logic [PS_W-1:0] ps_code,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Terminal value of the divider: 2^ps_code - 1 as a thermometer mask.
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(ps_code));
        end
    end

    assign tick = run && (div_q == mask);

    // Divider phase: restart on stop, clear or tick, otherwise advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || clear || tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // R4: with a nonzero code held steady, ticks are never back to back
    // R4
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ps_code != '0) |=> (!tick || ps_code != $past(ps_code)));

endmodule

// File: rtl/mtim_counter.sv
// Modulo up-counter: advances on tick, reloads the initial value after reaching the
// terminal value, and reports that wrap as a one-cycle pulse.
// Assumes: reload (a count write) has priority over a tick in the same cycle.
module mtim_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] init_val,
    input  logic [CNT_W-1:0] mod_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    assign count = cnt_q;
    assign wrap  = tick && !reload && (cnt_q == mod_val);

    // Count state: reload, wrap to initial value, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= init_val;
        end else if (tick) begin
            cnt_q <= (cnt_q == mod_val) ? init_val : cnt_q + 1'b1;
        end
    end

    // R5
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (count == $past(init_val)));

    // R3
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !reload) |=> $stable(count));

    // R6
    write_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (count == $past(init_val)));

endmodule

// File: rtl/mtim_top.sv
// Timer top: register decode, control/terminal/initial registers, wrap flag and
// interrupt, wired to the prescaler, counter and byte-lane adapter.
// Assumes: one write per strobe cycle; read data is a combinational mux of bus_addr.
module mtim_top #(
    parameter int ADDR_W     = 8,
    parameter int CNT_W      = 16,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    import mtim_pkg::*;

    localparam logic [CNT_W-1:0] MOD_RST = '1;

    logic [31:0]      wd;
    logic [31:0]      rd_int;
    ctl_t             ctl_q;
    logic [CNT_W-1:0] mod_q;
    logic [CNT_W-1:0] init_q;
    logic [CNT_W-1:0] count;
    logic             wr_ctl, wr_cnt, wr_mod, wr_init;
    logic             run, tick, wrap;

    mtim_lanes #(.BIG_ENDIAN(BIG_ENDIAN)) u_lanes (
        .wdata_ext (bus_wdata),
        .wdata_int (wd),
        .rdata_int (rd_int),
        .rdata_ext (bus_rdata)
    );

    // Write decode per register offset.
    always_comb begin
        wr_ctl  = bus_we && (bus_addr == ADDR_W'(OFS_CTL));
        wr_cnt  = bus_we && (bus_addr == ADDR_W'(OFS_CNT));
        wr_mod  = bus_we && (bus_addr == ADDR_W'(OFS_MOD));
        wr_init = bus_we && (bus_addr == ADDR_W'(OFS_INIT));
    end

    assign run = (ctl_q.src == SRC_RUN);

    mtim_prescaler #(.PS_W(PS_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .clear   (wr_cnt),
        .ps_code (ctl_q.ps),
        .tick    (tick)
    );

    mtim_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .reload   (wr_cnt),
        .init_val (init_q),
        .mod_val  (mod_q),
        .count    (count),
        .wrap     (wrap)
    );

    // Control fields written by software (flag handled separately).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.ps  <= '0;
            ctl_q.src <= '0;
            ctl_q.ie  <= 1'b0;
        end else if (wr_ctl) begin
            ctl_q.ps  <= wd[PS_W-1:0];
            ctl_q.src <= wd[SRC_LSB+1:SRC_LSB];
            ctl_q.ie  <= wd[IE_BIT];
        end
    end

    // Sticky wrap flag: a wrap sets it and wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.flag <= 1'b0;
        end else if (wrap) begin
            ctl_q.flag <= 1'b1;
        end else if (wr_ctl && !wd[FLAG_BIT]) begin
            ctl_q.flag <= 1'b0;
        end
    end

    // Terminal and initial values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q  <= MOD_RST;
            init_q <= '0;
        end else begin
            if (wr_mod)  mod_q  <= wd[CNT_W-1:0];
            if (wr_init) init_q <= wd[CNT_W-1:0];
        end
    end

    // Read mux in native lane order.
    always_comb begin
        rd_int = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTL):  rd_int = {24'b0, ctl_q.flag, ctl_q.ie, 1'b0, ctl_q.src, ctl_q.ps};
            ADDR_W'(OFS_CNT):  rd_int = 32'(count);
            ADDR_W'(OFS_MOD):  rd_int = 32'(mod_q);
            ADDR_W'(OFS_INIT): rd_int = 32'(init_q);
            default:           rd_int = '0;
        endcase
    end

    assign irq = ctl_q.flag && ctl_q.ie;

    // R8
    wrap_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && wr_ctl && !wd[FLAG_BIT]) |=> ctl_q.flag);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !wd[FLAG_BIT] && !wrap) |=> !ctl_q.flag);

    // R7
    no_write_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.flag && !wrap) |=> !ctl_q.flag);

    // R9
    irq_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && ctl_q.ie && !wr_ctl) |=> irq);

    // R3
    stopped_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !tick);

endmodule

// File: tb/tb_mtim_top.sv
// Scoreboard bench: driver tasks queue expected values, a negedge monitor pops and compares.
module tb_mtim_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_CTL = 8'h00, A_CNT = 8'h04, A_MOD = 8'h08, A_INIT = 8'h4C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] rdata, rdata_be;
    logic        irq, irq_be;

    always #(CLK_PERIOD/2) clk = ~clk;

    mtim_top dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(rdata), .irq(irq)
    );

    mtim_top #(.BIG_ENDIAN(1'b1)) dut_be (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(rdata_be), .irq(irq_be)
    );

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    item_t cur;
    logic [31:0] act;
    logic  mon_en = 1'b0;
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    // Monitor: compare the queued expectation with the sampled output.
    always @(negedge clk) begin
        if (mon_en && q.size() > 0) begin
            cur = q.pop_front();
            act = (cur.sel == 0) ? rdata : (cur.sel == 1) ? rdata_be : {31'b0, irq};
            n_vec++;
            if (act !== cur.exp) begin
                n_bad++;
                $display("FAIL %s: actual %08h expected %08h", cur.tag, act, cur.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    // sel: 0 = little-endian read, 1 = big-endian read, 2 = irq
    task automatic expect_at(input int sel, input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.sel = sel; it.exp = e; it.tag = tag;
        q.push_back(it);
        bus_addr = a; mon_en = 1'b1;
        @(posedge clk); #1;
        mon_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        #1;
        // R1 reset values
        expect_at(0, A_CTL, 32'h0, "R1 ctl");
        expect_at(0, A_CNT, 32'h0, "R1 cnt");
        expect_at(0, A_MOD, 32'h0000FFFF, "R1 mod");
        expect_at(0, A_INIT, 32'h0, "R1 init");
        expect_at(2, A_CTL, 32'h0, "R1 irq");

        // R10 big-endian lanes: only the swapped instance starts
        wr(A_CTL, 32'h08000000);
        idle(2);
        expect_at(1, A_CNT, 32'h02000000, "R10 be count");
        expect_at(1, A_CTL, 32'h08000000, "R10 be ctl");
        expect_at(0, A_CNT, 32'h0, "R10 le not started");
        expect_at(1, A_MOD, 32'hFFFF0000, "R10 be mod reset");
        wr(A_CTL, 32'h0);

        // R2 offsets, widths, field layout
        wr(A_MOD, 32'h00012345);
        expect_at(0, A_MOD, 32'h00002345, "R2 mod width");
        wr(A_INIT, 32'h0000ABCD);
        expect_at(0, A_INIT, 32'h0000ABCD, "R2 init");
        wr(A_CTL, 32'hFFFFFFFF);
        expect_at(0, A_CTL, 32'h0000005F, "R2 R7 ctl fields, flag not set by write");
        wr(A_CNT, 32'h12345678);
        expect_at(0, A_CNT, 32'h0000ABCD, "R6 count write loads init");
        idle(4);
        // R3 source select 3 holds the count
        expect_at(0, A_CNT, 32'h0000ABCD, "R3 source 3 holds");

        // R5 R9 R7 R8 basic wrap, N=5
        wr(A_CTL, 32'h0);
        wr(A_INIT, 32'h0);
        wr(A_MOD, 32'h4);
        wr(A_CNT, 32'h0);
        wr(A_CTL, 32'h08);
        expect_at(0, A_CNT, 32'd0, "R5 count 0");
        expect_at(0, A_CNT, 32'd1, "R5 count 1");
        expect_at(0, A_CNT, 32'd2, "R5 count 2");
        expect_at(0, A_CNT, 32'd3, "R5 count 3");
        expect_at(0, A_CNT, 32'd4, "R5 count at terminal");
        expect_at(0, A_CNT, 32'd0, "R5 wrap to init");
        expect_at(0, A_CTL, 32'h88, "R5 flag set");
        expect_at(2, A_CTL, 32'h0, "R9 irq masked");
        wr(A_CTL, 32'hC8);
        expect_at(2, A_CTL, 32'h1, "R9 irq asserted");
        wr(A_CTL, 32'h48);
        expect_at(2, A_CTL, 32'h0, "R7 irq after clear");
        expect_at(0, A_CTL, 32'h48, "R7 flag cleared");
        idle(1);
        wr(A_CTL, 32'h48);
        expect_at(0, A_CTL, 32'hC8, "R8 wrap beats clear");
        wr(A_CTL, 32'h48);
        expect_at(0, A_CTL, 32'h48, "R7 later clear");

        // R6 count write with nonzero init, R3 stop holds
        wr(A_CTL, 32'h0);
        wr(A_INIT, 32'h2);
        wr(A_CNT, 32'hDEAD);
        expect_at(0, A_CNT, 32'd2, "R6 reload init 2");
        idle(3);
        expect_at(0, A_CNT, 32'd2, "R3 stopped holds");

        // R4 prescaler code 2
        wr(A_INIT, 32'h0);
        wr(A_MOD, 32'd100);
        wr(A_CNT, 32'h0);
        wr(A_CTL, 32'h0A);
        idle(3);
        expect_at(0, A_CNT, 32'd0, "R4 before first tick");
        expect_at(0, A_CNT, 32'd1, "R4 first tick after 4 clocks");
        idle(2);
        expect_at(0, A_CNT, 32'd1, "R4 held between ticks");
        expect_at(0, A_CNT, 32'd2, "R4 second tick");
        // R6 count write restarts prescaler phase
        idle(1);
        wr(A_CNT, 32'h0);
        idle(3);
        expect_at(0, A_CNT, 32'd0, "R6 phase restarted");
        expect_at(0, A_CNT, 32'd1, "R6 full period after write");

        // R11 stop, reload, new terminal value, restart: N=3
        wr(A_CTL, 32'h0);
        wr(A_CNT, 32'h0);
        wr(A_MOD, 32'h2);
        wr(A_CTL, 32'h08);
        idle(2);
        expect_at(0, A_CTL, 32'h08, "R11 no early wrap");
        expect_at(0, A_CTL, 32'h88, "R11 wrap after full period");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule